// File: doc/BRIEF.md
# Page Write Gatherer with Timed Commit

This block sits behind the serial-bus front end of a small byte-wide nonvolatile store. When a write command arrives, the front end loads the start address once. After that it strobes each received data byte into the block. The block keeps those bytes in a small page buffer of eight slots. The slot for each byte is picked by the low three bits of a shared address pointer. Those bits step on every byte and wrap around inside the page, so any bytes beyond eight land on earlier slots and replace them. The upper pointer bits never move while bytes are gathered.

Nothing reaches the array while bytes are gathered. When the stop event arrives with at least one byte buffered, the block starts a self-timed write cycle. A busy flag rises and stays high for a fixed number of clock cycles, set by a parameter. The front end uses that flag to withhold acknowledges. During the first cycles of that window, the block walks the slots in ascending order. It drives the memory write port only for slots that were filled. A high write-protect level or a high supply-lockout level at stop throws the buffer away: the array is left alone and busy stays low. After a commit, the pointer is left one past the last byte written, wrapped within the page, so that a later current-address read can start from it.

Top module: `pwb_page_writer`

## Requirements
- R1: No memory write (`mem_we` high) happens outside the busy window; bytes strobed before stop leave the array untouched.
- R2: `addr_load` sets the pointer to `addr_in` and empties the buffer; each `byte_stb` stores `byte_in` in slot `ptr_out[2:0]`, then adds one to `ptr_out[2:0]` modulo 8 while `ptr_out[6:3]` stays fixed.
- R3: When more than eight bytes arrive before stop, each later byte replaces the one held in the same slot, and only the last value per slot is committed.
- R4: A stop with at least one byte buffered and both `wr_protect` and `supply_lock` low raises `busy` on the next clock edge and holds it high for exactly `WR_CYCLES` cycles.
- R5: During the first eight busy cycles, slot k is written in busy cycle k (k = 0..7) at address `{ptr_out[6:3], k}`, and only slots filled since the last `addr_load` are written.
- R6: A stop while `wr_protect` is high writes nothing, leaves `busy` low and empties the buffer.
- R7: A stop while `supply_lock` is high writes nothing, leaves `busy` low and empties the buffer.
- R8: A stop with an empty buffer writes nothing and leaves `busy` low.
- R9: While `busy` is high, `addr_load`, `byte_stb` and `stop_evt` have no effect on the pointer, the buffer or the busy window.
- R10: After a commit, `ptr_out` holds the last written address plus one, wrapped within its page.
- R11: A single-byte write takes the same path as a page write: one array write and a full-length busy window.
- R12: After reset, `busy` and `mem_we` are low, `ptr_out` is zero and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Loads the start address of a write command |
| addr_in | input | ADDR_W | Start address |
| byte_stb | input | 1 | One received data byte |
| byte_in | input | DATA_W | Data byte |
| stop_evt | input | 1 | Stop event that ends the command |
| wr_protect | input | 1 | Write-protect level, sampled at stop |
| supply_lock | input | 1 | Supply lockout level, sampled at stop |
| busy | output | 1 | Self-timed write cycle in progress |
| ptr_out | output | ADDR_W | Shared address pointer |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The gather-and-commit path is tried in several ways:
- Single bytes and full eight-byte pages separate the one-entry case from the full walk.
- Runs of nine to twelve bytes that start mid-page show whether replacement inside a slot and the wrap of the low pointer bits are right.
- Stops under write-protect, under lockout and with an empty buffer show whether the commit is gated or dropped.
- Strobes, loads and stops pushed into the middle of a busy window expose any input that leaks through.
- Random commands with a fixed seed mix start offsets, lengths and the two inhibit levels, checked against a bench model of the array and the pointer.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   // outcome of a stop event
   typedef enum logic [1:0] {
      STOP_IGNORE  = 2'd0,
      STOP_COMMIT  = 2'd1,
      STOP_DISCARD = 2'd2
   } stop_act_t;

   // shortest write cycle that still covers the slot walk
   function automatic int unsigned min_cycles(input int unsigned page_w);
      return (1 << page_w) + 1;
   endfunction
endpackage

// File: rtl/pwb_gather.sv
module pwb_gather #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load_i,
   input  logic [ADDR_W-1:0]               load_addr_i,
   input  logic                            stb_i,
   input  logic [DATA_W-1:0]               data_i,
   input  logic                            clear_i,
   output logic [ADDR_W-1:0]               ptr_o,
   output logic [(1<<PAGE_W)-1:0]          valid_o,
   output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] slots_o
);
   localparam int PAGE_N = 1 << PAGE_W;
   localparam int HI_W   = ADDR_W - PAGE_W;

   logic [HI_W-1:0]   ptr_hi_q;
   logic [PAGE_W-1:0] ptr_lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_hi_q <= '0;
         ptr_lo_q <= '0;
      end else if (load_i) begin
         ptr_hi_q <= load_addr_i[ADDR_W-1:PAGE_W];
         ptr_lo_q <= load_addr_i[PAGE_W-1:0];
      end else if (stb_i) begin
         ptr_lo_q <= ptr_lo_q + 1'b1;
      end
   end

   assign ptr_o = {ptr_hi_q, ptr_lo_q};

   for (genvar i = 0; i < PAGE_N; i++) begin : g_slot
      logic              vld_q;
      logic [DATA_W-1:0] dat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
         end else if (load_i || clear_i) begin
            vld_q <= 1'b0;
         end else if (stb_i && (ptr_lo_q == PAGE_W'(i))) begin
            vld_q <= 1'b1;
            dat_q <= data_i;
         end
      end
      assign valid_o[i] = vld_q;
      assign slots_o[i] = dat_q;
   end

   // R2
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i && !load_i |=> ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W]));

   // R2
   slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i && !load_i && !clear_i |=> valid_o != '0);
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
   parameter int CYCLES = 500,
   parameter int CNT_W  = $clog2(CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] count_o,
   output logic             done_o
);
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   assign done_o  = busy_q && (cnt_q == CNT_W'(CYCLES - 1));
   assign busy_o  = busy_q;
   assign count_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (done_o) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4
   window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   // R4
   window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o |=> busy_o);
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
   import pwb_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 3,
   parameter int WR_CYCLES = 500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_stb,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              stop_evt,
   input  logic              wr_protect,
   input  logic              supply_lock,
   output logic              busy,
   output logic [ADDR_W-1:0] ptr_out,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   localparam int PAGE_N = 1 << PAGE_W;
   localparam int CNT_W  = $clog2(WR_CYCLES);

   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must lie between 1 and ADDR_W-1");
   end
   if (WR_CYCLES < int'(min_cycles(PAGE_W))) begin : g_bad_cycles
      $error("WR_CYCLES too short for the slot walk");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [PAGE_N-1:0]             valid;
   logic [PAGE_N-1:0][DATA_W-1:0] slots;
   logic [CNT_W-1:0]              count;
   logic                          done;
   stop_act_t                     act;
   logic [PAGE_W-1:0]             walk_idx;
   logic                          in_walk;

   always_comb begin
      act = STOP_IGNORE;
      if (stop_evt && !busy && (valid != '0))
         act = (wr_protect || supply_lock) ? STOP_DISCARD : STOP_COMMIT;
   end

   pwb_gather #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
   ) u_gather (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (addr_load && !busy),
      .load_addr_i (addr_in),
      .stb_i       (byte_stb && !busy),
      .data_i      (byte_in),
      .clear_i     ((act == STOP_DISCARD) || done),
      .ptr_o       (ptr_out),
      .valid_o     (valid),
      .slots_o     (slots)
   );

   pwb_cycle_timer #(
      .CYCLES(WR_CYCLES), .CNT_W(CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (act == STOP_COMMIT),
      .busy_o  (busy),
      .count_o (count),
      .done_o  (done)
   );

   assign walk_idx  = count[PAGE_W-1:0];
   assign in_walk   = busy && (count < CNT_W'(PAGE_N));
   assign mem_we    = in_walk && valid[walk_idx];
   assign mem_addr  = {ptr_out[ADDR_W-1:PAGE_W], walk_idx};
   assign mem_wdata = slots[walk_idx];

   // R1
   array_write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   // R6
   protect_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt && !busy && wr_protect |=> !busy && !mem_we);

   // R7
   lock_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt && !busy && supply_lock |=> !busy && !mem_we);

   // R4
   busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt) && !$past(wr_protect) && !$past(supply_lock));

   // R9
   ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> $stable(ptr_out));
endmodule

// File: tb/pwb_page_writer_bench.sv
module pwb_page_writer_bench;
   localparam int WRC = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_load = 1'b0;
   logic [6:0] addr_in = '0;
   logic       byte_stb = 1'b0;
   logic [7:0] byte_in = '0;
   logic       stop_evt = 1'b0;
   logic       wr_protect = 1'b0;
   logic       supply_lock = 1'b0;
   logic       busy;
   logic [6:0] ptr_out;
   logic       mem_we;
   logic [6:0] mem_addr;
   logic [7:0] mem_wdata;

   int nchk = 0;
   int nfail = 0;
   int wr_count = 0;
   logic [7:0] dut_mem [128];
   logic [7:0] exp_mem [128];

   always #5 clk = ~clk;

   pwb_page_writer #(.WR_CYCLES(WRC)) u_pwb_page_writer (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
      .byte_stb(byte_stb), .byte_in(byte_in), .stop_evt(stop_evt),
      .wr_protect(wr_protect), .supply_lock(supply_lock), .busy(busy),
      .ptr_out(ptr_out), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   always @(negedge clk) begin
      if (mem_we) begin
         dut_mem[mem_addr] = mem_wdata;
         wr_count++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [6:0] next_ptr(input logic [6:0] p);
      return {p[6:3], p[2:0] + 3'd1};
   endfunction

   task automatic cmp_mem(input string req);
      int bad = -1;
      for (int a = 0; a < 128; a++)
         if (bad < 0 && dut_mem[a] !== exp_mem[a]) bad = a;
      if (bad < 0) chk(1'b1, req, "array", 0, 0);
      else chk(1'b0, req, $sformatf("array byte %0d", bad), dut_mem[bad], exp_mem[bad]);
   endtask

   task automatic run_cmd(input logic [6:0] start, input int n, input logic wp,
                          input logic lk, input bit poke, input string req);
      logic [7:0] sb [8];
      bit         sv [8];
      logic [6:0] p;
      int         nv = 0;
      int         cnt = 0;
      bit         commit;
      for (int k = 0; k < 8; k++) begin sb[k] = '0; sv[k] = 1'b0; end
      wr_count = 0;
      @(negedge clk);
      wr_protect = wp; supply_lock = lk;
      addr_load = 1'b1; addr_in = start;
      @(negedge clk);
      addr_load = 1'b0;
      p = start;
      for (int i = 0; i < n; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         byte_stb = 1'b1; byte_in = d;
         sb[p[2:0]] = d; sv[p[2:0]] = 1'b1;
         p = next_ptr(p);
         @(negedge clk);
      end
      byte_stb = 1'b0;
      #2;
      // R1: nothing written before stop
      chk(wr_count == 0, "R1", "writes before stop", wr_count, 0);
      // R2: pointer wrapped within page
      chk(ptr_out == p, "R2", "pointer after bytes", ptr_out, p);
      @(negedge clk);
      stop_evt = 1'b1;
      @(negedge clk);
      stop_evt = 1'b0;
      while (busy && cnt < 1000) begin
         cnt++;
         if (poke && cnt == 3) begin
            byte_stb = 1'b1; byte_in = 8'hEE; addr_load = 1'b1;
            addr_in = ~start; stop_evt = 1'b1;
         end else begin
            byte_stb = 1'b0; addr_load = 1'b0; stop_evt = 1'b0;
         end
         @(negedge clk);
      end
      byte_stb = 1'b0; addr_load = 1'b0; stop_evt = 1'b0;
      for (int k = 0; k < 8; k++) nv += int'(sv[k]);
      commit = (nv > 0) && !wp && !lk;
      // R4 / R6 / R7 / R8: busy window length
      chk(cnt == (commit ? WRC : 0), commit ? "R4" : (wp ? "R6" : (lk ? "R7" : "R8")),
          {req, " busy cycles"}, cnt, commit ? WRC : 0);
      if (commit)
         for (int k = 0; k < 8; k++)
            if (sv[k]) exp_mem[{start[6:3], 3'(k)}] = sb[k];
      #2;
      // R5 / R3: only filled slots written, last value wins
      chk(wr_count == (commit ? nv : 0), "R5", {req, " write count"},
          wr_count, commit ? nv : 0);
      cmp_mem(n > 8 ? "R3" : "R5");
      // R10 / R9: pointer left one past last byte
      chk(ptr_out == p, poke ? "R9" : "R10", {req, " pointer after commit"}, ptr_out, p);
      repeat (3) @(negedge clk);
      chk(!busy, poke ? "R9" : "R4", {req, " no second window"}, busy, 0);
      wr_protect = 1'b0; supply_lock = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int a = 0; a < 128; a++) begin dut_mem[a] = '0; exp_mem[a] = '0; end
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(busy == 1'b0, "R12", "busy in reset", busy, 0);
      chk(mem_we == 1'b0, "R12", "mem_we in reset", mem_we, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ptr_out == 7'd0, "R12", "pointer after reset", ptr_out, 0);
      // R8: stop with nothing buffered (buffer empty after reset)
      stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0; #2;
      chk(busy == 1'b0, "R12", "empty buffer at reset", busy, 0);

      run_cmd(7'h15, 1, 0, 0, 0, "R11 single byte");
      run_cmd(7'h20, 8, 0, 0, 0, "R5 full page");
      run_cmd(7'h46, 11, 0, 0, 0, "R3 overflow");
      run_cmd(7'h0E, 4, 0, 0, 0, "R2 mid-page wrap");
      run_cmd(7'h30, 5, 1, 0, 0, "R6 protect");
      run_cmd(7'h58, 3, 0, 1, 0, "R7 lockout");
      run_cmd(7'h61, 0, 0, 0, 0, "R8 empty stop");
      run_cmd(7'h7B, 6, 0, 0, 1, "R9 inputs while busy");
      for (int r = 0; r < 24; r++) begin
         int  rn;
         logic rwp, rlk;
         rn  = int'($urandom % 13);
         rwp = ($urandom % 6) == 0;
         rlk = ($urandom % 8) == 0;
         run_cmd(7'($urandom), rn, rwp, rlk, ($urandom % 4) == 0, "random");
      end

      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      #1000000;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule